// File: doc/BRIEF.md
# Row-Matching Hold-Grant Arbiter

This block is the switch arbiter on the router output port that leads to a memory controller. Each of `NUM_IN` inputs offers a valid flag and the DRAM row its pending memory request will open. One input wins each cycle in which the output port is ready. The aim is to stop request streams from different sources being interleaved on the way to DRAM, because interleaving breaks up runs of same-row accesses and costs row switches.

Three policies are available. Plain round-robin rotates priority after every grant. Hold-grant keeps granting the last winner while it still has a request. Row-matching hold-grant keeps granting the last winner only while its new request targets the row of the request it was last granted. In both sticky policies, a held input that drops its request or misses the row hands the decision back to round-robin. A parameterised limit on consecutive held grants forces a round-robin decision so a busy input cannot starve the others.

The policy input is sampled during reset and in any cycle where no input requests, so a policy change never takes effect in the middle of a stream.

Top module: `rmhg_arbiter`

## Requirements
- R1: `gnt_o` has at most one bit set, and it is all zero in any cycle where `out_rdy_i` is low.
- R2: A grant bit is set only for an input whose `req_vld_i` bit is high. When `out_rdy_i` is high and any input requests, exactly one grant bit is set.
- R3: Round-robin decision: the winner is the first requesting input found by scanning upward from the rotating pointer, wrapping from `NUM_IN-1` to 0. After an accepted round-robin grant, the pointer becomes winner+1 modulo `NUM_IN`.
- R4: Policy code 1 (hold-grant): if the last accepted winner is requesting again and the hold limit has not been reached, it is granted again. The pointer does not move.
- R5: Policy code 2 (row-matching): the last winner is granted again only when its current row (bits `[i*ROW_W +: ROW_W]` of `req_row_i` for input i) equals the row of its last accepted grant. Otherwise the round-robin decision applies. The pointer does not move on a held grant.
- R6: If the last winner is not requesting, the sticky policies fall back to the round-robin decision among the requesting inputs.
- R7: The remembered winner, the remembered row, the pointer and the hold count change only on an accepted grant. A cycle with `out_rdy_i` low leaves the next decision unaffected.
- R8: With `MAX_HOLD` > 0, after `MAX_HOLD` consecutive held grants the next decision is round-robin. Any round-robin grant clears the count.
- R9: `mode_i` is loaded during reset and in cycles where no input requests. A change of `mode_i` while any request is pending has no effect. Codes 0 and 3 both select round-robin.
- R10: After reset there is no remembered winner, the pointer is 0, and the hold count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Policy select: 0 round-robin, 1 hold-grant, 2 row-matching hold-grant, 3 round-robin |
| req_vld_i | input | NUM_IN | Per-input request valid |
| req_row_i | input | NUM_IN*ROW_W | Per-input DRAM row, input i in bits [i*ROW_W +: ROW_W] |
| out_rdy_i | input | 1 | Output port can accept a request this cycle |
| gnt_o | output | NUM_IN | One-hot grant, valid in the same cycle |

## Verification
The hardest case to reach is a held grant that hits the hold limit while the held input still matches its row. In that case the forced round-robin decision may pick the same input again or move to another one, depending on where the pointer was left several grants earlier. The random stimulus reaches this case by drawing each input's row from only two values and keeping request density high, which produces long same-row runs. A bench reference model follows the pointer, the remembered row and the hold count, and predicts every grant. Idle cycles and policy changes under load are inserted so that the policy latch is exercised both where it loads and where it must hold.

// File: rtl/rmhg_pkg.sv
package rmhg_pkg;

    typedef enum logic [1:0] {
        POL_RR   = 2'd0,
        POL_HOLD = 2'd1,
        POL_ROW  = 2'd2,
        POL_RSVD = 2'd3
    } policy_e;

    function automatic logic policy_sticky(input policy_e p);
        return (p == POL_HOLD) || (p == POL_ROW);
    endfunction

endpackage

// File: rtl/rmhg_rr_pick.sv
module rmhg_rr_pick #(
    parameter int NUM_IN = 4,
    localparam int IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
    input  logic [NUM_IN-1:0] req_i,
    input  logic [IDX_W-1:0]  ptr_i,
    output logic              any_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [IDX_W-1:0]  idx_inc_o
);

    // Scan from the pointer upward with wrap; first requester wins.
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int k = 0; k < NUM_IN; k++) begin
            int p;
            p = int'(ptr_i) + k;
            if (p >= NUM_IN) p = p - NUM_IN;
            if (!any_o && req_i[p]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(p);
            end
        end
    end

    // Pointer value one past the winner, wrapping at NUM_IN.
    always_comb begin
        if (int'(idx_o) == NUM_IN - 1) idx_inc_o = '0;
        else                           idx_inc_o = idx_o + IDX_W'(1);
    end

endmodule

// File: rtl/rmhg_hold_ctl.sv
module rmhg_hold_ctl
    import rmhg_pkg::*;
#(
    parameter int NUM_IN   = 4,
    parameter int ROW_W    = 8,
    parameter int MAX_HOLD = 3,
    localparam int IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
    localparam int HC_W  = $clog2(MAX_HOLD + 2)
) (
    input  policy_e                  policy_i,
    input  logic                     have_last_i,
    input  logic [IDX_W-1:0]         last_idx_i,
    input  logic [ROW_W-1:0]         last_row_i,
    input  logic [HC_W-1:0]          hold_cnt_i,
    input  logic [NUM_IN-1:0]        req_vld_i,
    input  logic [NUM_IN*ROW_W-1:0]  req_row_i,
    output logic                     hold_ok_o
);

    logic [ROW_W-1:0] cur_row;
    logic             still_req;
    logic             row_hit;
    logic             limit_hit;

    assign cur_row   = req_row_i[last_idx_i*ROW_W +: ROW_W];
    assign still_req = req_vld_i[last_idx_i];
    assign row_hit   = (cur_row == last_row_i);

    generate
        if (MAX_HOLD > 0) begin : g_limit
            assign limit_hit = (int'(hold_cnt_i) >= MAX_HOLD);
        end else begin : g_nolimit
            logic unused_cnt;
            assign unused_cnt = ^hold_cnt_i;
            assign limit_hit  = 1'b0;
        end
    endgenerate

    always_comb begin
        hold_ok_o = 1'b0;
        if (have_last_i && policy_sticky(policy_i) && still_req && !limit_hit) begin
            if (policy_i == POL_HOLD) hold_ok_o = 1'b1;
            else                      hold_ok_o = row_hit;
        end
    end

endmodule

// File: rtl/rmhg_arbiter.sv
module rmhg_arbiter
    import rmhg_pkg::*;
#(
    parameter int NUM_IN   = 4,
    parameter int ROW_W    = 8,
    parameter int MAX_HOLD = 3
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [1:0]               mode_i,
    input  logic [NUM_IN-1:0]        req_vld_i,
    input  logic [NUM_IN*ROW_W-1:0]  req_row_i,
    input  logic                     out_rdy_i,
    output logic [NUM_IN-1:0]        gnt_o
);

    localparam int IDX_W  = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;
    localparam int HC_W   = $clog2(MAX_HOLD + 2);
    localparam int HC_TOP = (1 << HC_W) - 1;

    typedef struct packed {
        policy_e          policy;
        logic [IDX_W-1:0] ptr;
        logic [IDX_W-1:0] last;
        logic [ROW_W-1:0] last_row;
        logic             have_last;
        logic [HC_W-1:0]  hold_cnt;
    } arb_state_t;

    arb_state_t st_q, st_d;

    logic             rr_any;
    logic [IDX_W-1:0] rr_idx;
    logic [IDX_W-1:0] rr_idx_inc;
    logic             hold_ok;
    logic             accept;
    logic [IDX_W-1:0] win_idx;

    rmhg_rr_pick #(
        .NUM_IN (NUM_IN)
    ) u_rr (
        .req_i     (req_vld_i),
        .ptr_i     (st_q.ptr),
        .any_o     (rr_any),
        .idx_o     (rr_idx),
        .idx_inc_o (rr_idx_inc)
    );

    rmhg_hold_ctl #(
        .NUM_IN   (NUM_IN),
        .ROW_W    (ROW_W),
        .MAX_HOLD (MAX_HOLD)
    ) u_hold (
        .policy_i    (st_q.policy),
        .have_last_i (st_q.have_last),
        .last_idx_i  (st_q.last),
        .last_row_i  (st_q.last_row),
        .hold_cnt_i  (st_q.hold_cnt),
        .req_vld_i   (req_vld_i),
        .req_row_i   (req_row_i),
        .hold_ok_o   (hold_ok)
    );

    assign accept  = out_rdy_i && rr_any;
    assign win_idx = hold_ok ? st_q.last : rr_idx;

    always_comb begin
        st_d  = st_q;
        gnt_o = '0;

        if (req_vld_i == '0) st_d.policy = policy_e'(mode_i);

        if (accept) begin
            gnt_o[win_idx]  = 1'b1;
            st_d.last       = win_idx;
            st_d.last_row   = req_row_i[win_idx*ROW_W +: ROW_W];
            st_d.have_last  = 1'b1;
            if (hold_ok) begin
                if (int'(st_q.hold_cnt) < HC_TOP) st_d.hold_cnt = st_q.hold_cnt + HC_W'(1);
            end else begin
                st_d.hold_cnt = '0;
                st_d.ptr      = rr_idx_inc;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.policy    <= policy_e'(mode_i);
            st_q.ptr       <= '0;
            st_q.last      <= '0;
            st_q.last_row  <= '0;
            st_q.have_last <= 1'b0;
            st_q.hold_cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_GNT_ONEHOT:   assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(gnt_o)); // R1
    AST_GNT_NEEDS_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni) !out_rdy_i |-> (gnt_o == '0)); // R1
    AST_GNT_HAS_REQ:  assert property (@(posedge clk_i) disable iff (!rst_ni) (gnt_o & ~req_vld_i) == '0); // R2
    AST_WORK_CONSERVE: assert property (@(posedge clk_i) disable iff (!rst_ni) (out_rdy_i && (req_vld_i != '0)) |-> (gnt_o != '0)); // R2
    AST_HELD_PTR_STILL: assert property (@(posedge clk_i) disable iff (!rst_ni) (accept && hold_ok) |=> $stable(st_q.ptr)); // R4
    AST_IDLE_KEEPS_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni) (gnt_o == '0) |=> ($stable(st_q.ptr) && $stable(st_q.last) && $stable(st_q.last_row) && $stable(st_q.hold_cnt))); // R7
    AST_POLICY_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni) (req_vld_i != '0) |=> $stable(st_q.policy)); // R9

    generate
        if (MAX_HOLD > 0) begin : g_hold_ast
            AST_HOLD_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni) (accept && int'(st_q.hold_cnt) == MAX_HOLD) |=> (st_q.hold_cnt == '0)); // R8
        end
    endgenerate

endmodule

// File: tb/rmhg_arbiter_tb.sv
module rmhg_arbiter_tb;

    localparam int N    = 4;
    localparam int RW   = 6;
    localparam int MAXH = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        mode = 2'd0;
    logic [N-1:0]      vld = '0;
    logic [N*RW-1:0]   rows = '0;
    logic              rdy = 1'b0;
    logic [N-1:0]      gnt;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // reference model state
    int         m_mode, m_ptr, m_last, m_hcnt;
    logic [RW-1:0] m_row;
    bit         m_have;

    always #4 clk = ~clk;

    rmhg_arbiter #(.NUM_IN(N), .ROW_W(RW), .MAX_HOLD(MAXH)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .req_vld_i(vld),
        .req_row_i(rows), .out_rdy_i(rdy), .gnt_o(gnt)
    );

    function automatic logic [RW-1:0] row_of(input logic [N*RW-1:0] r, input int i);
        return r[i*RW +: RW];
    endfunction

    task automatic do_reset(input logic [1:0] md);
        @(negedge clk);
        rst_n = 1'b0; mode = md; vld = '0; rdy = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        m_mode = int'(md); m_ptr = 0; m_last = 0; m_hcnt = 0; m_row = '0; m_have = 1'b0;
    endtask

    // one cycle: drive, predict, compare, advance model
    task automatic step(input logic [N-1:0] v, input logic [N*RW-1:0] r,
                        input logic rd, input logic [1:0] md, input string force_tag);
        bit held, sticky;
        int win;
        logic [N-1:0] exp;
        string tag;
        @(negedge clk);
        vld = v; rows = r; rdy = rd; mode = md;
        #2;
        sticky = (m_mode == 1 || m_mode == 2);
        held = m_have && sticky && v[m_last] &&
               (m_mode == 1 || row_of(r, m_last) == m_row) && (m_hcnt < MAXH);
        win = -1;
        if (held) win = m_last;
        else for (int k = 0; k < N; k++) begin
            int p;
            p = (m_ptr + k) % N;
            if (win < 0 && v[p]) win = p;
        end
        exp = '0;
        if (rd && win >= 0) exp[win] = 1'b1;
        if (!rd)                            tag = "R1";
        else if (v == '0)                   tag = "R2";
        else if (held)                      tag = (m_mode == 1) ? "R4" : "R5";
        else if (m_have && sticky && m_hcnt >= MAXH && v[m_last]) tag = "R8";
        else if (m_have && sticky && !v[m_last]) tag = "R6";
        else if (m_have && m_mode == 2)     tag = "R5";
        else                                tag = "R3";
        if (force_tag != "") tag = force_tag;
        n_tests++;
        if (gnt !== exp) begin
            n_fail++;
            $display("FAIL %s: gnt=%b expected=%b (vld=%b mode=%0d)", tag, gnt, exp, v, m_mode);
        end
        if (rd && win >= 0) begin
            m_last = win; m_row = row_of(r, win); m_have = 1'b1;
            if (held) m_hcnt++;
            else begin m_hcnt = 0; m_ptr = (win + 1) % N; end
        end
        if (v == '0) m_mode = int'(md);
    endtask

    function automatic logic [N*RW-1:0] rnd_rows();
        logic [N*RW-1:0] r;
        for (int i = 0; i < N; i++) r[i*RW +: RW] = RW'(i * 8 + ($urandom % 2));
        return r;
    endfunction

    initial begin
        logic [N*RW-1:0] same;
        void'($urandom(32'd1234));
        for (int i = 0; i < N; i++) same[i*RW +: RW] = RW'(i + 1);

        // R10: reset state, pointer at 0
        do_reset(2'd0);
        step(4'b1111, same, 1'b1, 2'd0, "R10");
        step(4'b1111, same, 1'b1, 2'd0, "R3");
        step(4'b1001, same, 1'b1, 2'd0, "R3");  // wrap toward 3
        step(4'b1001, same, 1'b1, 2'd0, "R3");  // wrap to 0
        // R7: ready low, requests change, then decision unchanged
        step(4'b0110, same, 1'b0, 2'd0, "R7");
        step(4'b1111, same, 1'b0, 2'd0, "R7");
        step(4'b1111, same, 1'b1, 2'd0, "R7");

        // R9: mode change under load is ignored
        step(4'b1111, same, 1'b1, 2'd1, "R9");
        step(4'b1111, same, 1'b1, 2'd1, "R9");
        step(4'b0000, same, 1'b1, 2'd1, "R9");  // idle: loads hold mode
        // R4 and R8 with a continuous requester
        for (int j = 0; j < 6; j++) step(4'b1111, same, 1'b1, 2'd1, "");
        step(4'b1110, same, 1'b1, 2'd1, "R6");

        // R5: row-matching, then a row miss
        step(4'b0000, same, 1'b1, 2'd2, "R9");
        step(4'b0100, same, 1'b1, 2'd2, "R5");
        step(4'b0110, same, 1'b1, 2'd2, "R5");
        same[2*RW +: RW] = RW'(40);
        step(4'b0110, same, 1'b1, 2'd2, "R5");

        // constrained random phases per mode
        for (int md = 0; md < 4; md++) begin
            step('0, rnd_rows(), 1'b1, 2'(md), "");
            for (int c = 0; c < 3000; c++) begin
                logic [N-1:0] v;
                logic [1:0]   mdr;
                v = N'($urandom) | N'($urandom);
                if ($urandom % 40 == 0) v = '0;
                mdr = ($urandom % 25 == 0) ? 2'($urandom) : 2'(md);
                step(v, rnd_rows(), ($urandom % 4) != 0, mdr, "");
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule